// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block moves data between a CPU bus and an 8-bit peripheral port under a two-wire handshake. It does not use plain register reads and writes. A direction input selects one of two channels.

In the receive direction, the peripheral pulls its active-low strobe low. That edge captures the port pins into a holding register and raises a buffer-full flag. When the strobe goes back high while the buffer is full, an interrupt request can be raised. The CPU read cycle then drops the request on its leading edge and frees the buffer on its trailing edge.

In the send direction, the trailing edge of a CPU write loads the port output latch and pulls the active-low output-full line low. The peripheral answers with an active-low acknowledge. Its leading edge releases output-full, and its trailing edge can raise the interrupt request. A single enable bit, set or cleared with a one-bit command, gates every request. The bus decode and the mode register are not part of this block: direction and the enable command arrive as plain inputs.

Top module: `hs_port_chan`

## Requirements
- R1: After reset, ibf is 0, obf_n is 1, intr is 0, pin_out and cpu_rdata are 0, and the interrupt enable is cleared.
- R2: With dir_out=0, a high-to-low change on stb_n copies pin_in into cpu_rdata and sets ibf, both visible one clock later.
- R3: With dir_out=0, a low-to-high change on rd_n clears ibf one clock later. If a strobe falling edge arrives in the same cycle, ibf stays set and the new data is captured. cpu_rdata holds its value until the next strobe falling edge.
- R4: With dir_out=0, a low-to-high change on stb_n while ibf is set and the enable is 1 raises intr one clock later. A high-to-low change on rd_n clears intr one clock later.
- R5: With dir_out=1, a low-to-high change on wr_n copies cpu_wdata to pin_out, drives obf_n to 0 and clears intr, all one clock later.
- R6: With dir_out=1, a high-to-low change on ack_n returns obf_n to 1 one clock later, and pin_out keeps its value.
- R7: With dir_out=1, a low-to-high change on ack_n while obf_n is 1 and the enable is 1 raises intr one clock later.
- R8: A pulse on ie_we loads ie_val into the interrupt enable. While the enable is 0, intr is 0, starting one clock after the clearing command, and no new request is raised.
- R9: While dir_out=1, ibf stays 0 and strobes are ignored. While dir_out=0, obf_n stays 1, write cycles leave pin_out unchanged, and pin_oe follows dir_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_out | input | 1 | 1 selects send channel, 0 selects receive channel |
| ie_we | input | 1 | Single-bit command strobe for the interrupt enable |
| ie_val | input | 1 | Value loaded into the enable on ie_we |
| rd_n | input | 1 | CPU read cycle, active low |
| wr_n | input | 1 | CPU write cycle, active low |
| cpu_wdata | input | W | Data from the CPU for the send channel |
| cpu_rdata | output | W | Captured receive data |
| pin_in | input | W | Port pins sampled on strobe |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pin_out | output | W | Latched send data |
| pin_oe | output | 1 | Output enable for the port pins |
| ibf | output | 1 | Receive buffer full |
| obf_n | output | 1 | Send buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
Every input edge is seen at the first rising clock edge where the new level is sampled. The flag, data and request changes it causes are all due exactly one clock after that edge, with no further stage. The exception is the masking by a cleared enable, which shows on intr after the same one clock. The bench drives each stimulus on a falling clock edge and queues the values due after the next rising edge. A monitor pops and compares them shortly after that rising edge, so every comparison lands in the single cycle where the result is due.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef struct packed {
        logic full;
        logic intr;
    } rx_flags_t;

    typedef struct packed {
        logic obf_n;
        logic intr;
    } tx_flags_t;

    localparam int EDGE_N   = 4;
    localparam int EDGE_RD  = 0;
    localparam int EDGE_WR  = 1;
    localparam int EDGE_STB = 2;
    localparam int EDGE_ACK = 3;

endpackage

// File: rtl/hs_edge.sv
module hs_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign fall[i] =  prev_q[i] & ~lvl[i];
        assign rise[i] = ~prev_q[i] &  lvl[i];
    end
endmodule

// File: rtl/hs_rx_chan.sv
module hs_rx_chan
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         ie,
    input  logic [W-1:0] pin_in,
    input  logic         stb_fall,
    input  logic         stb_rise,
    input  logic         rd_fall,
    input  logic         rd_rise,
    output logic [W-1:0] data,
    output logic         full,
    output logic         intr
);
    typedef struct packed {
        logic [W-1:0] data;
        rx_flags_t    f;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.f.full = 1'b0;
            st_d.f.intr = 1'b0;
        end else begin
            if (stb_fall) begin
                st_d.data   = pin_in;
                st_d.f.full = 1'b1;
            end else if (rd_rise) begin
                st_d.f.full = 1'b0;
            end
            if (rd_fall || !ie)
                st_d.f.intr = 1'b0;
            else if (stb_rise && st_q.f.full)
                st_d.f.intr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.f.full;
    assign intr = st_q.f.intr;
endmodule

// File: rtl/hs_tx_chan.sv
module hs_tx_chan
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         ie,
    input  logic [W-1:0] wdata,
    input  logic         wr_rise,
    input  logic         ack_fall,
    input  logic         ack_rise,
    output logic [W-1:0] data,
    output logic         obf_n,
    output logic         intr
);
    typedef struct packed {
        logic [W-1:0] data;
        tx_flags_t    f;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.f.obf_n = 1'b1;
            st_d.f.intr  = 1'b0;
        end else begin
            if (wr_rise) begin
                st_d.data    = wdata;
                st_d.f.obf_n = 1'b0;
            end else if (ack_fall) begin
                st_d.f.obf_n = 1'b1;
            end
            if (wr_rise || !ie)
                st_d.f.intr = 1'b0;
            else if (ack_rise && st_q.f.obf_n)
                st_d.f.intr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.f.obf_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data  = st_q.data;
    assign obf_n = st_q.f.obf_n;
    assign intr  = st_q.f.intr;
endmodule

// File: rtl/hs_port_chan.sv
module hs_port_chan
    import hs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_out,
    input  logic         ie_we,
    input  logic         ie_val,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic [W-1:0] pin_in,
    input  logic         stb_n,
    input  logic         ack_n,
    output logic [W-1:0] pin_out,
    output logic         pin_oe,
    output logic         ibf,
    output logic         obf_n,
    output logic         intr
);
    logic [EDGE_N-1:0] lvl, fall, rise;
    logic              ie_d, ie_q;
    logic              rx_intr, tx_intr;

    always_comb begin
        lvl           = '1;
        lvl[EDGE_RD]  = rd_n;
        lvl[EDGE_WR]  = wr_n;
        lvl[EDGE_STB] = stb_n;
        lvl[EDGE_ACK] = ack_n;
    end

    hs_edge #(.N(EDGE_N)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .fall (fall),
        .rise (rise)
    );

    always_comb begin
        ie_d = ie_q;
        if (ie_we) ie_d = ie_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else        ie_q <= ie_d;
    end

    hs_rx_chan #(.W(W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (!dir_out),
        .ie      (ie_q),
        .pin_in  (pin_in),
        .stb_fall(fall[EDGE_STB]),
        .stb_rise(rise[EDGE_STB]),
        .rd_fall (fall[EDGE_RD]),
        .rd_rise (rise[EDGE_RD]),
        .data    (cpu_rdata),
        .full    (ibf),
        .intr    (rx_intr)
    );

    hs_tx_chan #(.W(W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (dir_out),
        .ie      (ie_q),
        .wdata   (cpu_wdata),
        .wr_rise (rise[EDGE_WR]),
        .ack_fall(fall[EDGE_ACK]),
        .ack_rise(rise[EDGE_ACK]),
        .data    (pin_out),
        .obf_n   (obf_n),
        .intr    (tx_intr)
    );

    assign intr   = (rx_intr | tx_intr) & ie_q;
    assign pin_oe = dir_out;
endmodule

// File: rtl/hs_port_chan_chk.sv
module hs_port_chan_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dir_out,
    input logic         ie_we,
    input logic         ie_val,
    input logic         rd_n,
    input logic         wr_n,
    input logic [W-1:0] cpu_wdata,
    input logic         stb_n,
    input logic         ack_n,
    input logic [W-1:0] pin_out,
    input logic         ibf,
    input logic         obf_n,
    input logic         intr
);
    AST_STB_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !dir_out && $fell(stb_n)) |=> ibf); // R2
    AST_RD_FREES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !dir_out && $rose(rd_n) && !$fell(stb_n)) |=> !ibf); // R3
    AST_RD_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !dir_out && $fell(rd_n)) |=> !intr); // R4
    AST_WR_LOADS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dir_out && $rose(wr_n))
        |=> (!obf_n && !intr && pin_out == $past(cpu_wdata))); // R5
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dir_out && $fell(ack_n) && !$rose(wr_n)) |=> obf_n); // R6
    AST_ENABLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_we && !ie_val) |=> !intr); // R8
    AST_TX_DIR_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_out |=> !ibf); // R9
    AST_RX_DIR_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |=> obf_n); // R9
endmodule

bind hs_port_chan hs_port_chan_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_out  (dir_out),
    .ie_we    (ie_we),
    .ie_val   (ie_val),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .cpu_wdata(cpu_wdata),
    .stb_n    (stb_n),
    .ack_n    (ack_n),
    .pin_out  (pin_out),
    .ibf      (ibf),
    .obf_n    (obf_n),
    .intr     (intr)
);

// File: tb/hs_port_chan_tb.sv
`timescale 1ns/1ps
module hs_port_chan_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_out = 1'b0;
    logic         ie_we = 1'b0;
    logic         ie_val = 1'b0;
    logic         rd_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [W-1:0] cpu_wdata = '0;
    logic [W-1:0] pin_in = '0;
    logic         stb_n = 1'b1;
    logic         ack_n = 1'b1;
    logic [W-1:0] cpu_rdata, pin_out;
    logic         pin_oe, ibf, obf_n, intr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hs_port_chan #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .ie_we(ie_we), .ie_val(ie_val),
        .rd_n(rd_n), .wr_n(wr_n), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pin_in(pin_in), .stb_n(stb_n), .ack_n(ack_n), .pin_out(pin_out),
        .pin_oe(pin_oe), .ibf(ibf), .obf_n(obf_n), .intr(intr)
    );

    typedef struct {
        string        tag;
        logic         ibf;
        logic         obf_n;
        logic         intr;
        logic         oe;
        logic [W-1:0] rdata;
        logic [W-1:0] pout;
    } exp_t;

    exp_t sb[$];

    function automatic void compare(exp_t e);
        checks++;
        if (ibf !== e.ibf || obf_n !== e.obf_n || intr !== e.intr ||
            pin_oe !== e.oe || cpu_rdata !== e.rdata || pin_out !== e.pout) begin
            errors++;
            $display("FAIL %s: actual ibf=%b obf_n=%b intr=%b oe=%b rdata=%h pout=%h expected ibf=%b obf_n=%b intr=%b oe=%b rdata=%h pout=%h",
                     e.tag, ibf, obf_n, intr, pin_oe, cpu_rdata, pin_out,
                     e.ibf, e.obf_n, e.intr, e.oe, e.rdata, e.pout);
        end
    endfunction

    // driver: inputs were just set on a falling edge; queue what is due after the next rising edge
    task automatic expect_next(string tag, logic e_ibf, logic e_obf_n, logic e_intr,
                               logic [W-1:0] e_rd, logic [W-1:0] e_po);
        exp_t e;
        e.tag = tag; e.ibf = e_ibf; e.obf_n = e_obf_n; e.intr = e_intr;
        e.oe = dir_out; e.rdata = e_rd; e.pout = e_po;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R1..R9 run): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        // R1 during reset
        r.tag = "R1 in reset"; r.ibf = 0; r.obf_n = 1; r.intr = 0; r.oe = 0; r.rdata = '0; r.pout = '0;
        compare(r);
        rst_n = 1'b1;
        expect_next("R1 after release", 0, 1, 0, 8'h00, 8'h00);

        // receive direction
        ie_we = 1; ie_val = 1;        expect_next("R8 enable set", 0, 1, 0, 8'h00, 8'h00);
        ie_we = 0;
        pin_in = 8'hA5; stb_n = 0;    expect_next("R2 strobe latches", 1, 1, 0, 8'hA5, 8'h00);
        pin_in = 8'h3C; stb_n = 1;    expect_next("R4 strobe end raises intr", 1, 1, 1, 8'hA5, 8'h00);
        rd_n = 0;                     expect_next("R4 read start drops intr", 1, 1, 0, 8'hA5, 8'h00);
        rd_n = 1;                     expect_next("R3 read end frees buffer", 0, 1, 0, 8'hA5, 8'h00);
        stb_n = 0;                    expect_next("R2 second strobe", 1, 1, 0, 8'h3C, 8'h00);
        pin_in = 8'hFF;               expect_next("R3 data held without new edge", 1, 1, 0, 8'h3C, 8'h00);
        stb_n = 1;                    expect_next("R4 intr again", 1, 1, 1, 8'h3C, 8'h00);
        ie_we = 1; ie_val = 0;        expect_next("R8 clear masks intr", 1, 1, 0, 8'h3C, 8'h00);
        ie_val = 1;                   expect_next("R8 re-enable no stale intr", 1, 1, 0, 8'h3C, 8'h00);
        ie_we = 0;
        rd_n = 0;                     expect_next("R4 read start", 1, 1, 0, 8'h3C, 8'h00);
        rd_n = 1; stb_n = 0; pin_in = 8'h77;
                                      expect_next("R3 strobe wins over read end", 1, 1, 0, 8'h77, 8'h00);
        stb_n = 1;                    expect_next("R4 intr after priority case", 1, 1, 1, 8'h77, 8'h00);
        rd_n = 0;                     expect_next("R4 read drops intr", 1, 1, 0, 8'h77, 8'h00);
        rd_n = 1;                     expect_next("R3 buffer freed", 0, 1, 0, 8'h77, 8'h00);

        // send direction
        dir_out = 1; stb_n = 0; pin_in = 8'h11;
                                      expect_next("R9 strobe ignored in send", 0, 1, 0, 8'h77, 8'h00);
        stb_n = 1;                    expect_next("R9 ibf stays low", 0, 1, 0, 8'h77, 8'h00);
        cpu_wdata = 8'hC3; wr_n = 0;  expect_next("R5 write start no change", 0, 1, 0, 8'h77, 8'h00);
        wr_n = 1;                     expect_next("R5 write end loads port", 0, 0, 0, 8'h77, 8'hC3);
        ack_n = 0;                    expect_next("R6 ack empties", 0, 1, 0, 8'h77, 8'hC3);
        ack_n = 1;                    expect_next("R7 ack end raises intr", 0, 1, 1, 8'h77, 8'hC3);
        cpu_wdata = 8'h5A; wr_n = 0;  expect_next("R5 write start keeps intr", 0, 1, 1, 8'h77, 8'hC3);
        wr_n = 1;                     expect_next("R5 write end clears intr", 0, 0, 0, 8'h77, 8'h5A);
        ie_we = 1; ie_val = 0;        expect_next("R8 disable", 0, 0, 0, 8'h77, 8'h5A);
        ie_we = 0;
        ack_n = 0;                    expect_next("R6 ack with enable off", 0, 1, 0, 8'h77, 8'h5A);
        ack_n = 1;                    expect_next("R8 no intr while disabled", 0, 1, 0, 8'h77, 8'h5A);

        // back to receive: writes ignored
        dir_out = 0; cpu_wdata = 8'h99;
                                      expect_next("R9 direction back", 0, 1, 0, 8'h77, 8'h5A);
        wr_n = 0;                     expect_next("R9 write start ignored", 0, 1, 0, 8'h77, 8'h5A);
        wr_n = 1;                     expect_next("R9 write end ignored", 0, 1, 0, 8'h77, 8'h5A);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule